// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital sequencer of a dual-slope integrating analog-to-digital converter. After a start request it first shorts the integrator capacitor through a reset switch, with the input selector set to the unknown voltage. It then opens the switch and lets the unknown voltage charge the integrator for a fixed run-up interval of exactly 2^RES_BITS clock cycles. Next it turns the selector to the negative reference and counts clock cycles until the comparator shows that the integrator has crossed zero. That count is proportional to the input and is returned as the result.

The comparator arrives asynchronously and passes through a two-flop synchronizer before the sequencer reads it. If the integrator never crosses zero, the run-down stops at a count ceiling, raises an overflow flag and reports full scale. A conversion at tens of hertz spans millions of clocks, so every interval is a parameter and the counter is sized to match.

Top module: `dual_slope_ctrl`

## Requirements
- R1: After reset, zero_sw, sel_ref, busy, done, overflow and result are all 0.
- R2: When start is high in idle, on the next cycle zero_sw=1, sel_ref=0 and busy=1. This reset phase lasts exactly HOLD_CYCLES cycles.
- R3: After the reset phase, zero_sw=0 and sel_ref=0 (unknown input selected) for exactly 2^RES_BITS cycles of run-up.
- R4: After run-up, sel_ref=1 (negative reference selected) until the conversion ends. cmp_raw=1 means the integrator has not yet crossed zero. cmp_raw is used only after two synchronizer flops.
- R5: result equals the number of run-down cycles before the first run-down cycle in which the synchronized comparator reads 0. A crossing that comes D cycles later therefore gives a result exactly D larger.
- R6: If 2^(RES_BITS+1)-1 run-down cycles pass with the synchronized comparator still 1, the conversion ends with overflow=1 and result all ones. A conversion that ends on a crossing clears overflow.
- R7: done is high for exactly one cycle, in the cycle in which busy returns to 0. result and overflow change only together with done.
- R8: start is ignored while busy=1. It does not restart or lengthen any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a conversion (taken only when idle) |
| cmp_raw | input | 1 | Asynchronous comparator, 1 = integrator not yet crossed zero |
| zero_sw | output | 1 | Closes the integrator reset switch |
| sel_ref | output | 1 | Input selector: 0 = unknown input, 1 = negative reference |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Last conversion reached the count ceiling |
| result | output | RES_BITS+1 | Run-down count of the last conversion |

## Verification
The bench builds the block with RES_BITS=4 and HOLD_CYCLES=3. With these values a run-up lasts 16 cycles and the run-down ceiling is 31, so every phase boundary is visible within a few dozen cycles. Both the crossing path and the overflow path can be reached in one short run. Crossing delays of different sizes show that the result grows cycle for cycle with the delay. Start pulses placed inside the reset, run-up and run-down phases exercise the ignore rule in each phase.

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl #(
  parameter int RES_BITS    = 16,
  parameter int HOLD_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cmp_raw,
  output logic                zero_sw,
  output logic                sel_ref,
  output logic                busy,
  output logic                done,
  output logic                overflow,
  output logic [RES_BITS:0]   result
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int CW = (HW > RES_BITS + 1) ? HW : RES_BITS + 1;
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] RUN_LAST  = CW'((2 ** RES_BITS) - 1);
  localparam logic [CW-1:0] DN_LAST   = CW'((2 ** (RES_BITS + 1)) - 1);

  typedef enum logic [1:0] {IDLE, HOLD, RUNUP, RUNDN} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          s1, s2;

  assign zero_sw = (ph == HOLD);
  assign sel_ref = (ph == RUNDN);
  assign busy    = (ph != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= cmp_raw;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      overflow <= 1'b0;
      result   <= '0;
    end else begin
      done <= 1'b0;
      case (ph)
        IDLE: if (start) begin
          ph  <= HOLD;
          cnt <= '0;
        end
        HOLD: if (cnt == HOLD_LAST) begin
          ph  <= RUNUP;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        RUNUP: if (cnt == RUN_LAST) begin
          ph  <= RUNDN;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        RUNDN: if (!s2) begin
          ph       <= IDLE;
          done     <= 1'b1;
          overflow <= 1'b0;
          result   <= cnt[RES_BITS:0];
        end else if (cnt == DN_LAST) begin
          ph       <= IDLE;
          done     <= 1'b1;
          overflow <= 1'b1;
          result   <= '1;
        end else cnt <= cnt + 1'b1;
        default: ph <= IDLE;
      endcase
    end
  end

  // R2: a conversion can only begin out of idle
  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_sw) |-> $past(!busy));
  // R3: leaving the reset phase enters run-up on the unknown input
  assert_runup_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zero_sw) |-> (busy && !sel_ref));
  // R4: run-down is entered only from run-up
  assert_rundown_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ref) |-> $past(busy && !zero_sw));
  // R6: overflow completion reports full scale
  assert_full_scale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow) |-> (&result));
  // R7: done lasts one cycle and coincides with the return to idle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(sel_ref)));
  // R7: outputs hold between completions
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(overflow)));
  // R8: a start while busy never re-enters the reset phase
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !zero_sw) |=> !$rose(zero_sw));
endmodule

// File: tb/sim_dual_slope_ctrl.sv
module sim_dual_slope_ctrl;
  localparam int N    = 4;
  localparam int H    = 3;
  localparam int RUNC = 2 ** N;
  localparam int MAXC = 2 ** (N + 1) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp_raw = 1'b1;
  logic zero_sw, sel_ref, busy, done, overflow;
  logic [N:0] result;

  int checks = 0, failures = 0, cyc = 0;
  int xdelay = -1, seen = 0;
  int ph = 0, cnt = 0, mres = 0, mdone = 0, movf = 0, ms1 = 0, ms2 = 0;

  dual_slope_ctrl #(.RES_BITS(N), .HOLD_CYCLES(H)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_raw(cmp_raw),
    .zero_sw(zero_sw), .sel_ref(sel_ref), .busy(busy), .done(done),
    .overflow(overflow), .result(result));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int old;
    cyc++;
    if (!rst_n) begin
      ph = 0; cnt = 0; mres = 0; mdone = 0; movf = 0; ms1 = 0; ms2 = 0;
    end else begin
      old = ms2; ms2 = ms1; ms1 = int'(cmp_raw);
      mdone = 0;
      case (ph)
        0: if (start) begin ph = 1; cnt = 0; end
        1: if (cnt == H - 1) begin ph = 2; cnt = 0; end else cnt++;
        2: if (cnt == RUNC - 1) begin ph = 3; cnt = 0; end else cnt++;
        default: if (old == 0) begin
          ph = 0; mdone = 1; movf = 0; mres = cnt;
        end else if (cnt == MAXC) begin
          ph = 0; mdone = 1; movf = 1; mres = MAXC;
        end else cnt++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(zero_sw == (ph == 1), "R2", "zero_sw", int'(zero_sw), int'(ph == 1));
      chk(!(ph == 2) || (!zero_sw && !sel_ref), "R3", "runup switches", int'({zero_sw, sel_ref}), 0);
      chk(sel_ref == (ph == 3), "R4", "sel_ref", int'(sel_ref), int'(ph == 3));
      chk(int'(done) == mdone, "R7", "done", int'(done), mdone);
      chk(int'(result) == mres, "R5", "result", int'(result), mres);
      chk(int'(overflow) == movf, "R6", "overflow", int'(overflow), movf);
      chk(busy == (ph != 0), "R8", "busy", int'(busy), int'(ph != 0));
    end
    if (sel_ref) begin
      seen++;
      if (xdelay >= 0 && seen >= xdelay) cmp_raw <= 1'b0;
    end else begin
      seen = 0;
      cmp_raw <= 1'b1;
    end
  end

  task automatic convert(input int k, input int poke, output int res, output int ovf);
    int n;
    xdelay = k;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
      start = (n == poke);
    end
    start = 1'b0;
    res = int'(result);
    ovf = int'(overflow);
    @(negedge clk);
  endtask

  initial begin
    int r1, r5, r9, ra, o;
    repeat (3) @(negedge clk);
    chk({zero_sw, sel_ref, busy, done, overflow} == 5'b0 && result == '0, "R1", "reset outputs",
        int'({zero_sw, sel_ref, busy, done, overflow}) + int'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    convert(5, 0, r5, o);
    chk(o == 0, "R6", "overflow after crossing", o, 0);
    convert(9, 2, r9, o);
    chk(r9 - r5 == 4, "R5", "result slope", r9 - r5, 4);
    convert(1, 10, r1, o);
    chk(r5 - r1 == 4, "R5", "result slope low", r5 - r1, 4);
    convert(-1, 25, ra, o);
    chk(o == 1 && ra == MAXC, "R6", "full scale", ra, MAXC);
    convert(40, 0, ra, o);
    chk(o == 1, "R6", "late crossing overflow", o, 1);
    convert(3, 30, ra, o);
    chk(o == 0 && ra == r1 + 2, "R6", "overflow cleared", ra, r1 + 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule